// File: doc/BRIEF.md
# Block-Erase Flash Program Controller

This controller sits in front of a behavioural flash array and gives it the write rules of block-erased non-volatile storage. The erased state of every cell is 0. A program command can only raise bits: the stored word becomes the old word ORed with the new data. The only way back to 0 is an erase, which clears a whole block at once. The controller times program and erase itself and holds `busy_o` high while one runs. After each program it reads the word back and flags a mismatch with the requested data.

One block holds boot firmware and is guarded. A program or erase aimed at it is carried out only when the high-voltage qualifier is asserted in the same cycle as the command. Without the qualifier the command is refused, no cell changes and a protection flag is raised. Reads are random, take effect at once and need no qualifier. The block index is taken from the upper address bits. Block size, block count, word width and both operation durations are parameters.

Top module: `fpc_top`

## Requirements
- R1: After reset `busy_o`, `rvalid_o`, `verify_fail_o` and `prot_err_o` are 0, and every word of the array reads as 0.
- R2: A read command (`cmd_op_i` = 2'b00) accepted while idle raises `rvalid_o` for one cycle on the next clock edge, with `rdata_o` holding the word at `cmd_addr_i`.
- R3: An accepted program command (`cmd_op_i` = 2'b01) stores the old word ORed with `cmd_data_i`. No bit that is already 1 ever goes to 0 by programming.
- R4: At the end of each program `verify_fail_o` is 1 if the word read back differs from `cmd_data_i`, and 0 if it matches. An accepted program or erase clears it when it starts.
- R5: An accepted erase command (`cmd_op_i` = 2'b10) sets every word of the block selected by the upper address bits, `cmd_addr_i[ADDR_W-1 -: BLK_IDX_W]`, to 0. Words in other blocks keep their values.
- R6: `busy_o` is high for exactly PROG_CYC+1 cycles after an accepted program and for exactly ERASE_CYC cycles after an accepted erase.
- R7: Any command presented while `busy_o` is high is ignored. It produces no `rvalid_o` and changes no cell, and the running operation keeps its duration.
- R8: A program or erase addressing block BOOT_BLK (default 0) with `cmd_hv_i` low is rejected: no cell changes, `busy_o` stays 0, `prot_err_o` becomes 1 and `verify_fail_o` keeps its value.
- R9: The same command with `cmd_hv_i` high, or any program or erase to another block whatever `cmd_hv_i` is, is accepted and clears `prot_err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present this cycle |
| cmd_op_i | input | 2 | 00 read, 01 program, 10 erase, 11 no operation |
| cmd_addr_i | input | ADDR_W | Word address; the upper bits select the block |
| cmd_data_i | input | DATA_W | Program data |
| cmd_hv_i | input | 1 | High-voltage qualifier for the boot block |
| busy_o | output | 1 | Program or erase in progress |
| rdata_o | output | DATA_W | Read data |
| rvalid_o | output | 1 | Read data valid, one-cycle pulse |
| verify_fail_o | output | 1 | Last program read back wrongly |
| prot_err_o | output | 1 | Last program or erase was refused as unqualified |

## Verification
A read answers on the first clock edge after it is accepted, so the monitor takes `rvalid_o` and `rdata_o` at the falling edge that follows and compares them with the head of a queue of expected words that the driver filled. For a program or an erase, the driver counts the falling edges at which `busy_o` is high. It expects PROG_CYC+1 for a program, ERASE_CYC for an erase and 0 for a refused command. It checks the status flags only once `busy_o` has dropped, which is when the verify result is in place. Commands issued during an erase must leave no read pulse behind, and a `rvalid_o` that arrives while the queue is empty is counted as a mismatch.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_PROG  = 2'b01,
    OP_ERASE = 2'b10,
    OP_NONE  = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PROG,
    ST_VERIFY,
    ST_ERASE
  } state_e;
endpackage

// File: rtl/fpc_array.sv
module fpc_array #(
  parameter int DATA_W    = 8,
  parameter int BLK_WORDS = 16,
  parameter int BLK_NUM   = 4,
  localparam int WORDS     = BLK_WORDS * BLK_NUM,
  localparam int ADDR_W    = $clog2(WORDS),
  localparam int BLK_AW    = $clog2(BLK_WORDS),
  localparam int BLK_IDX_W = $clog2(BLK_NUM)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    rd_addr_i,
  output logic [DATA_W-1:0]    rd_data_o,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    wr_addr_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  input  logic                 ers_en_i,
  input  logic [BLK_IDX_W-1:0] ers_blk_i
);
  logic [DATA_W-1:0] mem [WORDS];
  logic [WORDS-1:0]  ers_hit;

  for (genvar g = 0; g < WORDS; g++) begin : g_hit
    assign ers_hit[g] = ers_en_i && (BLK_IDX_W'(g / BLK_WORDS) == ers_blk_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < WORDS; w++) mem[w] <= '0;
    end else begin
      // programming can only raise bits
      if (wr_en_i) mem[wr_addr_i] <= mem[wr_addr_i] | wr_data_i;
      for (int w = 0; w < WORDS; w++) if (ers_hit[w]) mem[w] <= '0;
    end
  end

  assign rd_data_o = mem[rd_addr_i];

  logic [DATA_W-1:0] old_word;
  assign old_word = mem[wr_addr_i];

  assert_prog_keeps_ones_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> ((mem[$past(wr_addr_i)] & $past(old_word)) == $past(old_word)));

  assert_erase_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ers_en_i |=> (mem[{$past(ers_blk_i), {BLK_AW{1'b0}}}] == '0));
endmodule

// File: rtl/fpc_guard.sv
module fpc_guard
  import fpc_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int BLK_IDX_W = 2,
  parameter int BOOT_BLK  = 0
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  op_e               op_i,
  input  logic              hv_i,
  output logic              blocked_o
);
  logic [BLK_IDX_W-1:0] blk;
  assign blk       = addr_i[ADDR_W-1 -: BLK_IDX_W];
  assign blocked_o = (op_i == OP_PROG || op_i == OP_ERASE)
                     && (blk == BLK_IDX_W'(BOOT_BLK)) && !hv_i;
endmodule

// File: rtl/fpc_seq.sv
module fpc_seq
  import fpc_pkg::*;
#(
  parameter int PROG_CYC  = 2,
  parameter int ERASE_CYC = 8,
  localparam int MAX_CYC  = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC,
  localparam int CNT_W    = $clog2(MAX_CYC + 1)
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_prog_i,
  input  logic   start_erase_i,
  output logic   busy_o,
  output logic   prog_we_o,
  output logic   verify_o,
  output logic   erase_en_o
);
  state_e           state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_prog_i) begin
            state_q <= ST_PROG;
            cnt_q   <= CNT_W'(PROG_CYC - 1);
          end else if (start_erase_i) begin
            state_q <= ST_ERASE;
            cnt_q   <= CNT_W'(ERASE_CYC - 1);
          end
        end
        ST_PROG: begin
          if (cnt_q == '0) state_q <= ST_VERIFY;
          else cnt_q <= cnt_q - 1'b1;
        end
        ST_VERIFY: state_q <= ST_IDLE;
        ST_ERASE: begin
          if (cnt_q == '0) state_q <= ST_IDLE;
          else cnt_q <= cnt_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign prog_we_o  = (state_q == ST_PROG)  && (cnt_q == '0);
  assign erase_en_o = (state_q == ST_ERASE) && (cnt_q == '0);
  assign verify_o   = (state_q == ST_VERIFY);

  assert_prog_to_verify_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_we_o |=> (state_q == ST_VERIFY));

  assert_erase_runs_on_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ERASE && cnt_q != '0) |=> (state_q == ST_ERASE && cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/fpc_top.sv
module fpc_top
  import fpc_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int BLK_WORDS = 16,
  parameter int BLK_NUM   = 4,
  parameter int BOOT_BLK  = 0,
  parameter int PROG_CYC  = 2,
  parameter int ERASE_CYC = 8,
  localparam int WORDS     = BLK_WORDS * BLK_NUM,
  localparam int ADDR_W    = $clog2(WORDS),
  localparam int BLK_IDX_W = $clog2(BLK_NUM)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_op_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  input  logic              cmd_hv_i,
  output logic              busy_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              verify_fail_o,
  output logic              prot_err_o
);
  op_e               op;
  logic              blocked, accept, start_prog, start_erase;
  logic              prog_we, verify, erase_en;
  logic [ADDR_W-1:0] addr_q, arr_raddr;
  logic [DATA_W-1:0] data_q, arr_rdata;

  assign op          = op_e'(cmd_op_i);
  assign accept      = cmd_valid_i && !busy_o;
  assign start_prog  = accept && (op == OP_PROG)  && !blocked;
  assign start_erase = accept && (op == OP_ERASE) && !blocked;
  assign arr_raddr   = busy_o ? addr_q : cmd_addr_i;

  fpc_guard #(.ADDR_W(ADDR_W), .BLK_IDX_W(BLK_IDX_W), .BOOT_BLK(BOOT_BLK)) i_guard (
    .addr_i(cmd_addr_i), .op_i(op), .hv_i(cmd_hv_i), .blocked_o(blocked));

  fpc_seq #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) i_seq (
    .clk_i, .rst_ni, .start_prog_i(start_prog), .start_erase_i(start_erase),
    .busy_o, .prog_we_o(prog_we), .verify_o(verify), .erase_en_o(erase_en));

  fpc_array #(.DATA_W(DATA_W), .BLK_WORDS(BLK_WORDS), .BLK_NUM(BLK_NUM)) i_array (
    .clk_i, .rst_ni, .rd_addr_i(arr_raddr), .rd_data_o(arr_rdata),
    .wr_en_i(prog_we), .wr_addr_i(addr_q), .wr_data_i(data_q),
    .ers_en_i(erase_en), .ers_blk_i(addr_q[ADDR_W-1 -: BLK_IDX_W]));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q        <= '0;
      data_q        <= '0;
      rdata_o       <= '0;
      rvalid_o      <= 1'b0;
      verify_fail_o <= 1'b0;
      prot_err_o    <= 1'b0;
    end else begin
      rvalid_o <= accept && (op == OP_READ);
      if (accept && op == OP_READ) rdata_o <= arr_rdata;
      if (start_prog || start_erase) begin
        addr_q        <= cmd_addr_i;
        data_q        <= cmd_data_i;
        verify_fail_o <= 1'b0;
        prot_err_o    <= 1'b0;
      end else if (accept && blocked) begin
        prot_err_o <= 1'b1;
      end
      if (verify) verify_fail_o <= (arr_rdata != data_q);
    end
  end

  assert_reject_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && blocked) |=> (!busy_o && prot_err_o));

  assert_read_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> !$past(busy_o));

  assert_accept_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_prog || start_erase) |=> (busy_o && !prot_err_o));
endmodule

// File: tb/test_fpc_top.sv
module test_fpc_top;
  localparam int DATA_W = 8, BLK_WORDS = 16, BLK_NUM = 4;
  localparam int PROG_CYC = 2, ERASE_CYC = 8;
  localparam int WORDS = BLK_WORDS * BLK_NUM;
  localparam int ADDR_W = $clog2(WORDS);

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cmd_valid = 1'b0, cmd_hv = 1'b0;
  logic [1:0] cmd_op = 2'b11;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic [DATA_W-1:0] cmd_data = '0;
  logic busy, rvalid, vfail, perr;
  logic [DATA_W-1:0] rdata;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [DATA_W-1:0] model [WORDS];
  logic [DATA_W-1:0] exp_q [$];
  logic exp_vf = 1'b0, exp_pe = 1'b0;

  always #10 clk = ~clk;

  fpc_top #(.DATA_W(DATA_W), .BLK_WORDS(BLK_WORDS), .BLK_NUM(BLK_NUM),
            .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) i_fpc_top (
    .clk_i(clk), .rst_ni, .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_addr_i(cmd_addr), .cmd_data_i(cmd_data), .cmd_hv_i(cmd_hv),
    .busy_o(busy), .rdata_o(rdata), .rvalid_o(rvalid),
    .verify_fail_o(vfail), .prot_err_o(perr));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: pops expected read data as results appear
  always @(negedge clk) if (rvalid) begin
    if (exp_q.size() == 0) chk(1'b0, "R7 unexpected rvalid", 1, 0);
    else begin
      logic [DATA_W-1:0] e;
      e = exp_q.pop_front();
      chk(rdata == e, "R2 read data", rdata, e);
    end
  end

  task automatic do_read(input int a);
    @(negedge clk);
    cmd_valid = 1; cmd_op = 2'b00; cmd_addr = ADDR_W'(a);
    exp_q.push_back(model[a]);
    @(negedge clk);
    cmd_valid = 0; cmd_op = 2'b11;
    @(negedge clk);
  endtask

  function automatic bit is_blocked(input int a, input bit hv);
    return (a / BLK_WORDS == 0) && !hv;
  endfunction

  task automatic do_mod(input bit erase, input int a, input logic [DATA_W-1:0] d, input bit hv);
    int n = 0;
    int exp_n;
    bit blk;
    blk = is_blocked(a, hv);
    exp_n = blk ? 0 : (erase ? ERASE_CYC : PROG_CYC + 1);
    @(negedge clk);
    cmd_valid = 1; cmd_op = erase ? 2'b10 : 2'b01;
    cmd_addr = ADDR_W'(a); cmd_data = d; cmd_hv = hv;
    @(negedge clk);
    cmd_valid = 0; cmd_op = 2'b11; cmd_hv = 0;
    while (busy) begin n++; @(negedge clk); end
    if (blk) exp_pe = 1;
    else begin
      exp_pe = 0;
      if (erase) begin
        exp_vf = 0;
        for (int w = 0; w < WORDS; w++) if (w / BLK_WORDS == a / BLK_WORDS) model[w] = '0;
      end else begin
        model[a] = model[a] | d;
        exp_vf = (model[a] != d);
      end
    end
    chk(n == exp_n, blk ? "R8 busy stays low" : "R6 busy length", n, exp_n);
    chk(vfail == exp_vf, "R4 verify flag", vfail, exp_vf);
    chk(perr == exp_pe, blk ? "R8 protection flag" : "R9 protection cleared", perr, exp_pe);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < WORDS; w++) model[w] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !rvalid, "R1 idle after reset", {busy, rvalid}, 0);
    chk(!vfail && !perr, "R1 status after reset", {vfail, perr}, 0);
    do_read(0); do_read(20); do_read(63);
    // R3/R9 program outside boot block without qualifier
    do_mod(0, 20, 8'h5A, 0);
    do_read(20);
    // R3/R4 overlapping program: 5A | 0F = 5F, mismatch
    do_mod(0, 20, 8'h0F, 0);
    do_read(20);
    do_mod(0, 21, 8'hA5, 0);
    do_mod(0, 20, 8'h5F, 0);  // R4 match clears flag
    do_read(21);
    // R8 unqualified program to boot block
    do_mod(0, 3, 8'h3C, 0);
    do_read(3);
    // R9 qualified program to boot block
    do_mod(0, 3, 8'h3C, 1);
    do_read(3);
    // R8 unqualified erase of boot block keeps data
    do_mod(1, 5, 8'h00, 0);
    do_read(3);
    // R5 erase block 1 only
    do_mod(1, 30, 8'h00, 0);
    do_read(20); do_read(21); do_read(3);
    // R7 commands while busy are ignored
    @(negedge clk);
    cmd_valid = 1; cmd_op = 2'b10; cmd_addr = 0; cmd_hv = 1;
    @(negedge clk);
    begin
      int n = 1;
      cmd_op = 2'b00; cmd_addr = 3; cmd_hv = 0;
      @(negedge clk); n++;
      cmd_op = 2'b01; cmd_addr = 40; cmd_data = 8'hFF;
      @(negedge clk); n++;
      cmd_valid = 0; cmd_op = 2'b11;
      @(negedge clk);
      while (busy) begin n++; @(negedge clk); end
      chk(n == ERASE_CYC, "R7 erase length kept", n, ERASE_CYC);
    end
    for (int w = 0; w < BLK_WORDS; w++) model[w] = '0;
    do_read(40);
    do_read(3);
    chk(exp_q.size() == 0, "R7 no pending reads", exp_q.size(), 0);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule